// File: doc/BRIEF.md
# Dual Position Counter Capture and Clear Unit

This block keeps two position counters and can copy either or both into a private capture register. Three things can start a capture. The first is a chosen edge on an external latch pin. The second is the origin (home) pin going high. The third is a capture command written through the register port. For each counter, configuration bits decide whether the latch pin and the origin pin act on it. A per-counter option zeroes the live count in the same cycle that its value is captured, so the next reading is measured from the capture point.

Captures caused by the latch pin and by the origin pin each set their own sticky flag. Each flag has its own interrupt enable, and the single interrupt output combines the enabled flags. Software uses a small synchronous register port to write configuration and commands, and to read the captured values, the live counts, the pin levels and the flags. The counters have no reset pin. Software zeroes them with a command, or lets a capture zero them through the clear-after-capture option.

Top module: `cnt_capture_unit`

## Requirements
- R1: After reset, every readable register, both counters, both capture registers and both flags read 0, and `irq` is 0.
- R2: In each cycle where `cnt_en[i]` is 1, counter i steps up by one if `cnt_up[i]` is 1 and down by one otherwise. It wraps modulo 2^CNT_W.
- R3: Configuration bit 0 (address 0) selects the active edge of the latch pin: 1 for rising, 0 for falling. The opposite edge captures nothing.
- R4: Configuration bits 3 and 4 mask the latch pin for counter 1 and counter 2. A 1 stops that counter from being captured by the latch pin.
- R5: Configuration bits 5 and 6 enable origin capture for counter 1 and counter 2. A rising origin pin captures only the enabled counters, and a falling origin pin captures nothing.
- R6: Writing opcode 0x29 to the command register (address 2) captures both counters in the same cycle, whatever the masks and origin enables are, and sets no flag.
- R7: Configuration bits 1 and 2 enable clear-after-capture for counter 1 and counter 2. A capture stores the count as it was before that cycle. With the option on, the counter then holds 0 plus that cycle's step; with it off, the counter is undisturbed.
- R8: Opcode 0x20 zeroes counter 1 and opcode 0x21 zeroes counter 2. Any other opcode except 0x29 changes nothing.
- R9: Status (address 3) gives the synchronized latch-pin level in bit 0 and the origin-pin level in bit 1. Bit 2 is the latch-pin capture flag and bit 3 is the origin capture flag. A flag is set when its pin captures at least one counter, and it stays set until a read of address 3 with `rd_en`. If a set and a clear fall in the same cycle, the set wins.
- R10: `irq` is 1 exactly when (flag bit 2 and interrupt-enable bit 0) or (flag bit 3 and interrupt-enable bit 1) holds. The interrupt enables are at address 1.
- R11: Each pin passes through a two-flop synchronizer. Its level appears in status after the second rising clock edge following the change, and the capture is registered on the third.
- R12: Address 4 and address 5 read the capture registers, and address 6 and address 7 read the live counters, all zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_in | input | 1 | Asynchronous external latch pin |
| origin_in | input | 1 | Asynchronous origin pin, active high |
| cnt_en | input | 2 | Per-counter count step enable |
| cnt_up | input | 2 | Per-counter direction, 1 counts up |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a strobe at address 3 clears the flags |
| addr | input | 3 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- counter stepping;
- that a capture stores the pre-step count;
- that clear-after-capture leaves the step as the new count;
- that the capture command captures both counters;
- that the flags stay set until a status read;
- that the interrupt rises only after a hardware trigger or a write to the interrupt enables.

Edge polarity, per-counter masks and origin enables can only be shown by the bench's scenarios. The same is true of synchronizer latency, opcode decoding and read-to-clear. The bench sweeps every combination of polarity, mask and clear setting with both pin edges, and every origin enable and clear setting.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int NCNT = 2;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_IEN  = 3'd1;
    localparam logic [2:0] A_CMD  = 3'd2;
    localparam logic [2:0] A_STS  = 3'd3;
    localparam logic [2:0] A_LAT1 = 3'd4;
    localparam logic [2:0] A_LAT2 = 3'd5;
    localparam logic [2:0] A_CNT1 = 3'd6;
    localparam logic [2:0] A_CNT2 = 3'd7;

    localparam logic [7:0] OP_LATCH = 8'h29;
    localparam logic [7:0] OP_CLR1  = 8'h20;

    // packed MSB first: org_en = bits 6:5, lt_mask = 4:3, clr_en = 2:1, lt_rise = 0
    typedef struct packed {
        logic [NCNT-1:0] org_en;
        logic [NCNT-1:0] lt_mask;
        logic [NCNT-1:0] clr_en;
        logic            lt_rise;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sh[STAGES-1];
    assign rise  = level & ~st_q.prev;
    assign fall  = ~level & st_q.prev;
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         step_up,
    input  logic         cap,
    input  logic         clr_after,
    input  logic         clr_cmd,
    output logic [W-1:0] cnt,
    output logic [W-1:0] lat
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lat;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] step;
    logic [W-1:0] base;

    always_comb begin
        st_d = st_q;
        if (step_en) step = step_up ? W'(1) : {W{1'b1}};
        else         step = '0;
        base     = ((cap && clr_after) || clr_cmd) ? '0 : st_q.cnt;
        st_d.cnt = base + step;
        if (cap) st_d.lat = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign lat = st_q.lat;
endmodule

// File: rtl/cnt_capture_unit.sv
module cnt_capture_unit
    import cap_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DW        = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_in,
    input  logic            origin_in,
    input  logic [1:0]      cnt_en,
    input  logic [1:0]      cnt_up,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [2:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            irq
);
    typedef struct packed {
        cfg_t      cfg;
        logic [1:0] irq_en;
        logic [1:0] flag;   // [0] latch pin, [1] origin pin
    } reg_t;

    reg_t rg_d, rg_q;

    logic [1:0] pins;
    logic [1:0] lvl, rise, fall;
    logic       lt_trig, og_trig, cmd_wr, cmd_latch, sts_rd;
    logic [NCNT-1:0]            cap, clr_cmd;
    logic [NCNT-1:0][CNT_W-1:0] cnt_q, lat_q;
    logic [1:0] flag_q;
    logic       unused_ok;

    assign pins = {origin_in, latch_in};

    for (genvar p = 0; p < 2; p++) begin : g_pin
        cap_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[p]),
            .level(lvl[p]),
            .rise (rise[p]),
            .fall (fall[p])
        );
    end

    always_comb begin
        lt_trig   = rg_q.cfg.lt_rise ? rise[0] : fall[0];
        og_trig   = rise[1];
        cmd_wr    = wr_en && (addr == A_CMD);
        cmd_latch = cmd_wr && (wdata[7:0] == OP_LATCH);
        sts_rd    = rd_en && (addr == A_STS);
        for (int i = 0; i < NCNT; i++) begin
            cap[i]     = cmd_latch
                       | (lt_trig & ~rg_q.cfg.lt_mask[i])
                       | (og_trig &  rg_q.cfg.org_en[i]);
            clr_cmd[i] = cmd_wr && (wdata[7:0] == OP_CLR1 + 8'(i));
        end
    end

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        cap_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_en  (cnt_en[i]),
            .step_up  (cnt_up[i]),
            .cap      (cap[i]),
            .clr_after(rg_q.cfg.clr_en[i]),
            .clr_cmd  (clr_cmd[i]),
            .cnt      (cnt_q[i]),
            .lat      (lat_q[i])
        );
    end

    always_comb begin
        rg_d = rg_q;
        if (wr_en && addr == A_CFG) rg_d.cfg    = cfg_t'(wdata[CFG_W-1:0]);
        if (wr_en && addr == A_IEN) rg_d.irq_en = wdata[1:0];
        if (sts_rd) rg_d.flag = '0;
        if (lt_trig && !(&rg_q.cfg.lt_mask)) rg_d.flag[0] = 1'b1;
        if (og_trig && (|rg_q.cfg.org_en))   rg_d.flag[1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (addr)
            A_CFG:   rdata = DW'(rg_q.cfg);
            A_IEN:   rdata = DW'(rg_q.irq_en);
            A_STS:   rdata = DW'({rg_q.flag, lvl});
            A_LAT1:  rdata = DW'(lat_q[0]);
            A_LAT2:  rdata = DW'(lat_q[1]);
            A_CNT1:  rdata = DW'(cnt_q[0]);
            A_CNT2:  rdata = DW'(cnt_q[1]);
            default: rdata = '0;
        endcase
    end

    assign flag_q    = rg_q.flag;
    assign irq       = |(rg_q.flag & rg_q.irq_en);
    assign unused_ok = ^{wdata[DW-1:8], fall[1]};
endmodule

// File: rtl/cnt_capture_chk.sv
module cnt_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [2:0]            addr,
    input logic [7:0]            wbyte,
    input logic [1:0]            cnt_en,
    input logic [1:0]            cnt_up,
    input logic                  irq,
    input logic [1:0][CNT_W-1:0] cnt_q,
    input logic [1:0][CNT_W-1:0] lat_q,
    input logic [1:0]            cap,
    input logic [1:0]            clr_cmd,
    input logic [1:0]            clr_en,
    input logic [1:0]            flag_q,
    input logic                  lt_trig,
    input logic                  og_trig
);
    a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en[0] && cnt_up[0] && !cap[0] && !clr_cmd[0])
        |=> cnt_q[0] == CNT_W'($past(cnt_q[0]) + CNT_W'(1)));

    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en[1] && !cnt_up[1] && !cap[1] && !clr_cmd[1])
        |=> cnt_q[1] == CNT_W'($past(cnt_q[1]) - CNT_W'(1)));

    a_r7_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap[0] |=> lat_q[0] == $past(cnt_q[0]));

    a_r7_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
        (cap[1] && clr_en[1] && !cnt_en[1]) |=> cnt_q[1] == '0);

    a_r6_cmd_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && wbyte == 8'h29)
        |=> (lat_q[0] == $past(cnt_q[0]) && lat_q[1] == $past(cnt_q[1])));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !(rd_en && addr == 3'd3)) |=> flag_q[0]);

    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(lt_trig || og_trig || (wr_en && addr == 3'd1)));
endmodule

bind cnt_capture_unit cnt_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wbyte  (wdata[7:0]),
    .cnt_en (cnt_en),
    .cnt_up (cnt_up),
    .irq    (irq),
    .cnt_q  (cnt_q),
    .lat_q  (lat_q),
    .cap    (cap),
    .clr_cmd(clr_cmd),
    .clr_en (rg_q.cfg.clr_en),
    .flag_q (flag_q),
    .lt_trig(lt_trig),
    .og_trig(og_trig)
);

// File: tb/cnt_capture_unit_tb.sv
`timescale 1ns/1ps
module cnt_capture_unit_tb;
    localparam int CW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n, latch_in, origin_in, wr_en, rd_en, irq;
    logic [1:0]    cnt_en, cnt_up;
    logic [2:0]    addr;
    logic [DW-1:0] wdata, rdata;

    int            n_chk = 0, n_bad = 0;
    logic [CW-1:0] ec [2];
    logic [CW-1:0] elat [2];
    logic          eflt, efog;
    logic [1:0]    ien;

    always #10 clk = ~clk;

    cnt_capture_unit #(.CNT_W(CW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .latch_in(latch_in), .origin_in(origin_in),
        .cnt_en(cnt_en), .cnt_up(cnt_up), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic clr_sts();
        addr = 3'd3; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; eflt = 1'b0; efog = 1'b0;
    endtask

    task automatic zero_counts();
        wr(3'd2, 32'h20); wr(3'd2, 32'h21);
        ec[0] = '0; ec[1] = '0;
    endtask

    task automatic run_counts(input int n1, input int n2);
        for (int k = 0; k < (n1 > n2 ? n1 : n2); k++) begin
            cnt_up = 2'b01;
            cnt_en = {k < n2, k < n1};
            @(negedge clk);
        end
        cnt_en = 2'b00;
        ec[0] = ec[0] + CW'(n1);
        ec[1] = ec[1] - CW'(n2);
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(3'd4, v); chk(req, v, 32'(elat[0]));
        rd(3'd5, v); chk(req, v, 32'(elat[1]));
        rd(3'd6, v); chk(req, v, 32'(ec[0]));
        rd(3'd7, v); chk(req, v, 32'(ec[1]));
        rd(3'd3, v); chk(req, v, {28'd0, efog, eflt, origin_in, latch_in});
        chk(req, {31'd0, irq}, {31'd0, (eflt & ien[0]) | (efog & ien[1])});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v1, v2;
        rst_n = 1'b0; latch_in = 1'b0; origin_in = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        cnt_en = 2'b00; cnt_up = 2'b00; addr = '0; wdata = '0;
        ec[0] = '0; ec[1] = '0; elat[0] = '0; elat[1] = '0;
        eflt = 1'b0; efog = 1'b0; ien = 2'b00;
        cyc(3); rst_n = 1'b1; cyc(1);

        // R1 reset state, R12 read map
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); chk("R1", v, 32'd0);
        end
        chk("R1", {31'd0, irq}, 32'd0);

        // R2 up/down with wrap
        run_counts(7, 3);
        check_all("R2 R12");

        // R11 synchronizer latency
        wr(3'd0, 32'h01); clr_sts();
        latch_in = 1'b1;
        cyc(2);
        rd(3'd3, v); chk("R11", v & 32'h1, 32'h1);
        rd(3'd4, v); chk("R11", v, 32'(elat[0]));
        cyc(1);
        elat[0] = ec[0]; elat[1] = ec[1]; eflt = 1'b1;
        check_all("R11");
        latch_in = 1'b0; cyc(4);
        check_all("R3");

        // R3/R4/R7 sweep: polarity, masks, clear-after-capture
        for (int c = 0; c < 32; c++) begin
            wr(3'd0, 32'(c));
            zero_counts();
            run_counts(3 + c, 1 + c % 5);
            ien = 2'b01; wr(3'd1, 32'(ien));
            clr_sts();
            for (int t = 0; t < 2; t++) begin
                logic hit;
                latch_in = ~latch_in;
                cyc(4);
                hit = (latch_in == c[0]);
                for (int i = 0; i < 2; i++) begin
                    if (hit && !c[3 + i]) begin
                        elat[i] = ec[i];
                        if (c[1 + i]) ec[i] = '0;
                    end
                end
                if (hit && !(c[3] && c[4])) eflt = 1'b1;
                check_all("R3 R4 R7");
            end
        end

        // R5/R7 sweep: origin enables and clear
        for (int c = 0; c < 16; c++) begin
            wr(3'd0, (32'(c[3:2]) << 5) | (32'(c[1:0]) << 1));
            zero_counts();
            run_counts(2 + c, 1 + c);
            ien = 2'b10; wr(3'd1, 32'(ien));
            clr_sts();
            origin_in = 1'b1; cyc(4);
            for (int i = 0; i < 2; i++) begin
                if (c[2 + i]) begin
                    elat[i] = ec[i];
                    if (c[i]) ec[i] = '0;
                end
            end
            if (c[3:2] != 2'b00) efog = 1'b1;
            check_all("R5 R7");
            origin_in = 1'b0; cyc(4);
            check_all("R5");
        end

        // R9 read clears flags
        clr_sts();
        check_all("R9");

        // R6 command captures despite masks, no flag
        wr(3'd0, 32'h18);
        zero_counts();
        run_counts(9, 4);
        clr_sts();
        wr(3'd2, 32'h29);
        elat[0] = ec[0]; elat[1] = ec[1];
        check_all("R6");

        // R8 opcodes
        wr(3'd2, 32'h22);
        check_all("R8");
        wr(3'd2, 32'h21); ec[1] = '0;
        check_all("R8");

        // R7 capture with simultaneous step
        wr(3'd0, 32'h06);
        zero_counts();
        cnt_up = 2'b11; cnt_en = 2'b11;
        cyc(5);
        rd(3'd6, v1); rd(3'd7, v2);
        chk("R7", v1, 32'd5);
        addr = 3'd2; wdata = 32'h29; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 2'b00;
        elat[0] = CW'(v1); elat[1] = CW'(v2); ec[0] = CW'(1); ec[1] = CW'(1);
        check_all("R7");

        // R10 interrupt masking
        ien = 2'b00; wr(3'd1, 32'h0);
        wr(3'd0, 32'h20);
        origin_in = 1'b1; cyc(4);
        elat[0] = ec[0]; efog = 1'b1;
        origin_in = 1'b0; cyc(4);
        check_all("R10");
        ien = 2'b10; wr(3'd1, 32'h2);
        check_all("R10");
        ien = 2'b01; wr(3'd1, 32'h1);
        check_all("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule